// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block takes four asynchronous interrupt pins from outside the chip and turns each into a clean, maskable request toward a processor. Each pin is first brought into the system clock domain. It is then handled in one of two ways, chosen per line. In edge mode a qualifying transition is latched until software acknowledges it. In level mode the request tracks the pin while it is at its active level.

All per-line settings live in one 32-bit configuration word, written and read through a plain register port. For each line the word holds:

- a request enable;
- an acknowledge strobe;
- a polarity select;
- a select that makes any transition count;
- a level/edge mode select.

Every line has its own request output, so vectoring and priority are left to the consumer.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset, reg_rdata_o reads 0x000F0000 (all lines level mode, active-low, disabled) and irq_o is 0.
- R2: Configuration fields: enable at bits [3:0], acknowledge at [7:4], polarity at [11:8], any-edge at [15:12], level mode at [19:16], with bit n of each field for line n. A write stores enable, polarity, any-edge and mode exactly. The acknowledge field and bits [31:20] always read 0.
- R3: irq_o[n] is 0 whenever enable bit n is 0, and equals the line status when the bit is 1.
- R4: In level mode (mode bit 1) the status is 1 exactly when the synchronized pin equals the polarity bit (1 = active-high, 0 = active-low). An acknowledge write has no effect on it. In level mode the edge latch is held cleared.
- R5: In edge mode with any-edge 0 and polarity 1, a rising transition of the pin sets a latched status that stays 1 until acknowledged. A falling transition does not set it.
- R6: In edge mode with any-edge 0 and polarity 0, a falling transition sets the latched status. A rising transition does not set it.
- R7: In edge mode with any-edge 1, both rising and falling transitions set the latched status, whatever the polarity bit is.
- R8: Writing 1 to acknowledge bit n clears the latched edge status of line n on that clock edge. If a new qualifying edge is seen in the same cycle, the status stays 1.
- R9: The lines are independent. Configuration, pin activity and acknowledges of one line never change the status of another.
- R10: Take a pin change that is stable before clock edge k. It reaches irq_o after edge k+1 in level mode and after edge k+2 in edge mode (two synchronizer flops plus one edge-history flop).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| reg_we_i | input | 1 | Configuration write strobe |
| reg_wdata_i | input | 32 | Configuration write data |
| reg_rdata_o | output | 32 | Configuration read data |
| irq_o | output | 4 | Per-line interrupt request |

## Verification
The in-RTL assertions check on every cycle that:
- a disabled line never requests;
- the acknowledge field always reads 0;
- a latched edge survives any cycle without an acknowledge;
- a detected edge beats a concurrent acknowledge;
- level mode keeps the edge latch empty.

Only the bench's scenarios can show the following:
- the per-mode selection of rising, falling or any transition;
- the exact synchronizer latency;
- that acknowledges leave level-mode lines untouched;
- that lines do not disturb each other.

The bench compares every cycle against its own cycle model, driven by both directed and random configuration and pin traffic.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned CFG_W     = 32;
  // field LSBs, one bit per line
  localparam int unsigned EN_LSB    = 0;
  localparam int unsigned ACK_LSB   = 4;
  localparam int unsigned POL_LSB   = 8;
  localparam int unsigned ANY_LSB   = 12;
  localparam int unsigned LVL_LSB   = 16;
  localparam int unsigned USED_MSB  = LVL_LSB + NUM_LINES - 1;

  typedef struct packed {
    logic en;
    logic pol;
    logic any_edge;
    logic lvl_mode;
  } line_cfg_t;

  localparam line_cfg_t LINE_CFG_RST = '{en: 1'b0, pol: 1'b0, any_edge: 1'b0, lvl_mode: 1'b1};
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_sense_pkg::*;
#(
  parameter int unsigned N = NUM_LINES,
  parameter int unsigned W = CFG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output line_cfg_t [N-1:0] cfg_o,
  output logic [N-1:0]     ack_o
);
  line_cfg_t [N-1:0] cfg_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[W-1:USED_MSB+1];

  for (genvar n = 0; n < N; n++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[n] <= LINE_CFG_RST;
      end else if (we_i) begin
        cfg_q[n].en       <= wdata_i[EN_LSB+n];
        cfg_q[n].pol      <= wdata_i[POL_LSB+n];
        cfg_q[n].any_edge <= wdata_i[ANY_LSB+n];
        cfg_q[n].lvl_mode <= wdata_i[LVL_LSB+n];
      end
    end
    // acknowledge is a strobe, never stored
    assign ack_o[n] = we_i & wdata_i[ACK_LSB+n];
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < N; n++) begin
      rdata_o[EN_LSB+n]  = cfg_q[n].en;
      rdata_o[POL_LSB+n] = cfg_q[n].pol;
      rdata_o[ANY_LSB+n] = cfg_q[n].any_edge;
      rdata_o[LVL_LSB+n] = cfg_q[n].lvl_mode;
    end
  end

  assign cfg_o = cfg_q;

  p_ack_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[ACK_LSB+N-1:ACK_LSB] == '0);
endmodule

// File: rtl/irq_line_sense.sv
module irq_line_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  input  logic any_edge_i,
  input  logic lvl_mode_i,
  input  logic ack_i,
  output logic status_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic smp, prev_q, rise, fall, edge_hit, latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= smp;
    end
  end

  assign smp  = sync_q[SYNC_STAGES-1];
  assign rise = smp & ~prev_q;
  assign fall = ~smp & prev_q;
  assign edge_hit = any_edge_i ? (rise | fall) : (pol_i ? rise : fall);

  // new edge wins over a concurrent acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          latch_q <= 1'b0;
    else if (lvl_mode_i)  latch_q <= 1'b0;
    else if (edge_hit)    latch_q <= 1'b1;
    else if (ack_i)       latch_q <= 1'b0;
  end

  assign status_o = lvl_mode_i ? (smp == pol_i) : latch_q;

  p_latch_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_mode_i && latch_q && !ack_i) |=> latch_q);
  p_edge_beats_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_mode_i && edge_hit) |=> latch_q);
  p_level_no_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_mode_i |=> !latch_q);
endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
  import irq_sense_pkg::*;
#(
  parameter int unsigned N           = NUM_LINES,
  parameter int unsigned W           = CFG_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic         reg_we_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic [N-1:0] irq_o
);
  line_cfg_t [N-1:0] cfg;
  logic [N-1:0] ack, status, en;

  irq_cfg_regs #(.N(N), .W(W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg),
    .ack_o   (ack)
  );

  for (genvar n = 0; n < N; n++) begin : g_line
    irq_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[n]),
      .pol_i      (cfg[n].pol),
      .any_edge_i (cfg[n].any_edge),
      .lvl_mode_i (cfg[n].lvl_mode),
      .ack_i      (ack[n]),
      .status_o   (status[n])
    );
    assign en[n] = cfg[n].en;
  end

  assign irq_o = status & en;

  p_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~reg_rdata_o[EN_LSB+N-1:EN_LSB]) == '0);
endmodule

// File: tb/ext_irq_sense_ctrl_tb.sv
module ext_irq_sense_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] pin = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0] irq;

  always #2.5 clk = ~clk;

  ext_irq_sense_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] m_cfg;
  logic [3:0] m_s1, m_s2, m_prev, m_latch;

  function automatic logic [3:0] exp_irq(input logic [31:0] c, input logic [3:0] s, input logic [3:0] l);
    logic [3:0] r;
    for (int n = 0; n < 4; n++)
      r[n] = c[n] & (c[16+n] ? (s[n] == c[8+n]) : l[n]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] p, input bit w, input logic [31:0] d, input string tag);
    logic [3:0] ack, lat_n;
    @(negedge clk);
    pin = p; we = w; wdata = d;
    ack = w ? d[7:4] : 4'h0;
    for (int n = 0; n < 4; n++) begin
      logic r, f, hit;
      r = m_s2[n] & ~m_prev[n];
      f = ~m_s2[n] & m_prev[n];
      hit = m_cfg[12+n] ? (r | f) : (m_cfg[8+n] ? r : f);
      lat_n[n] = m_cfg[16+n] ? 1'b0 : (hit ? 1'b1 : (ack[n] ? 1'b0 : m_latch[n]));
    end
    @(posedge clk);
    #1;
    m_latch = lat_n;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = p;
    if (w) m_cfg = d & 32'h000F_FF0F;
    check({tag, " irq"}, {28'h0, irq}, {28'h0, exp_irq(m_cfg, m_s2, m_latch)});
    check({tag, " rdata"}, rdata, m_cfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] p;
    void'($urandom(32'd1234));
    m_cfg = 32'h000F_0000; m_s1 = '0; m_s2 = '0; m_prev = '0; m_latch = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rdata", rdata, 32'h000F_0000);
    check("R1 reset irq", {28'h0, irq}, 32'h0);
    rst_ni = 1'b1;

    // R3: active-low level, disabled -> quiet
    for (int i = 0; i < 4; i++) step(4'h0, 0, 0, "R3 disabled");
    // R2: readback, ack and high bits read zero
    step(4'h0, 1, 32'hFFF5_A5F3, "R2 readback");
    step(4'h0, 1, 32'h000F_00FF, "R2 readback");
    // R4: active-low level, ack ignored
    step(4'h5, 0, 0, "R10 level latency");
    step(4'h5, 0, 0, "R4 level low");
    step(4'h5, 1, 32'h000F_00FF, "R4 ack ignored");
    step(4'h5, 1, 32'h000F_0FFF, "R4 level high");
    step(4'hA, 0, 0, "R4 level high");
    step(4'hA, 0, 0, "R4 level high");
    // R5: rising edge
    step(4'h0, 1, 32'h0000_0F0F, "R5 rising cfg");
    step(4'h0, 0, 0, "R5");
    step(4'h0, 0, 0, "R5");
    step(4'h3, 0, 0, "R10 edge latency");
    step(4'h3, 0, 0, "R10 edge latency");
    step(4'h0, 0, 0, "R5 rising latched");
    step(4'h0, 0, 0, "R5 falling ignored");
    step(4'h0, 1, 32'h0000_0FFF, "R8 ack");
    step(4'h0, 0, 0, "R8 cleared");
    // R6: falling edge
    step(4'hF, 1, 32'h0000_000F, "R6 falling cfg");
    step(4'hF, 0, 0, "R6 rising ignored");
    step(4'hF, 0, 0, "R6 rising ignored");
    step(4'hF, 0, 0, "R6 rising ignored");
    step(4'h9, 0, 0, "R6 falling");
    step(4'h9, 0, 0, "R6 falling");
    step(4'h9, 0, 0, "R6 latched");
    // R8: edge in same cycle as ack
    step(4'h0, 0, 0, "R8 setup");
    step(4'h0, 0, 0, "R8 setup");
    step(4'h0, 1, 32'h0000_00FF, "R8 edge beats ack");
    step(4'h0, 0, 0, "R8 still latched");
    // R7: any edge, both polarities
    step(4'h0, 1, 32'h0000_F0FF, "R7 any cfg");
    step(4'hF, 0, 0, "R7");
    step(4'hF, 0, 0, "R7");
    step(4'hF, 0, 0, "R7 rise");
    step(4'hF, 1, 32'h0000_FFFF, "R7 ack pol1");
    step(4'h0, 0, 0, "R7");
    step(4'h0, 0, 0, "R7");
    step(4'h0, 0, 0, "R7 fall pol1");
    // R9: random mixed traffic
    for (int i = 0; i < 600; i++) begin
      p = 4'($urandom);
      if (($urandom % 8) == 0) step(p, 1, $urandom, "R9 random");
      else step(p, 0, 0, "R9 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule